// File: doc/BRIEF.md
# Dual-Channel Phase Detector and Lock Monitor

This block sits behind the reference and feedback dividers of two frequency synthesizer channels. Both edge streams are sampled in the reference clock domain. For each channel it runs a three-state phase/frequency detector. The detector result goes out as a charge-pump command made of two signals: a drive level and a separate output enable. When the enable is low, the pump output is meant to float.

The block measures how long each phase error pulse lasts, in reference clock cycles, and keeps a lock flag per channel. The unlock and relock rules are asymmetric:

- A single long pulse drops lock at once.
- Lock comes back only after several consecutive short comparisons.

The two per-channel flags combine into one lock indication. A channel that is in power save counts as locked. That indication shares one output pin with a monitor path, which can instead show the raw reference or feedback edge stream of either channel.

Top module: `plm_top`

## Requirements
- R1: A reference edge sampled on a clock edge, with no feedback edge on the same clock edge, raises `cp_oe` from that clock edge until the clock edge on which the next feedback edge is sampled. The opposite order behaves the same way with the roles swapped. While `cp_oe` is high, `cp_drive` equals `pol` when the reference leads and equals `~pol` when the feedback leads.
- R2: If a reference edge and a feedback edge are sampled on the same clock edge while the detector is idle, `cp_oe` stays low. That event counts as a comparison of width zero.
- R3: While `sleep[i]` is high, `cp_oe[i]` and `cp_drive[i]` are 0 in the same cycle, and the detector and lock state of channel i are cleared. The channel counts as locked for the combined indication. After wake-up it starts unlocked.
- R4: Once `cp_oe[i]` has been high for `UNLOCK_W` (default 2) consecutive cycles, the lock flag of channel i is 0 from the clock edge that ends the `UNLOCK_W`-th cycle.
- R5: A comparison is good if it is a completed error pulse of fewer than `UNLOCK_W` and at most `RELOCK_W` (default 4) cycles, or a zero-width event. After `QUAL_CNT` (default 3) consecutive good comparisons, the flag is set on the clock edge that completes the last one. Any unlock event restarts the count.
- R6: With `lds` = 0, `ld_mon` is 1 only when every channel is locked or sleeping.
- R7: With `lds` = 1, `ld_mon` shows an input directly. The pair {`mon_ch`, `mon_fb`} selects it: 00 shows `fr[0]`, 10 shows `fr[1]`, 01 shows `fp[0]`, and 11 shows `fp[1]`.
- R8: After reset, both channels are unlocked, both `cp_oe` bits are 0, and `ld_mon` is 0 when `lds` = 0.
- R9: An error pulse of one cycle leaves an existing lock set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| sleep | input | 2 | Per-channel power save |
| fr | input | 2 | Per-channel divided reference pulse stream |
| fp | input | 2 | Per-channel divided feedback pulse stream |
| pol | input | 2 | Per-channel detector polarity |
| lds | input | 1 | 1 selects the monitor path onto `ld_mon` |
| mon_ch | input | 1 | Monitor channel select |
| mon_fb | input | 1 | Monitor: 0 reference, 1 feedback |
| cp_drive | output | 2 | Charge-pump drive level per channel |
| cp_oe | output | 2 | Charge-pump output enable per channel |
| ld_mon | output | 1 | Combined lock indication or monitored stream |

## Verification
The bench goes after the width thresholds:

- A two-cycle pulse must drop lock, while a one-cycle pulse must not. A detector whose counter is off by one would either hold a false lock through a real slip, or chatter on near-zero error.

Relock is exercised with an unlock pulse placed in the middle of a good run. A design that does not restart the qualification count on unlock would relock one or two comparisons early.

Coincident edges, polarity flips, sleep entry with a pulse in flight, and all four monitor selections are also driven. This catches a wrong drive sense, a pump left enabled during power save, and a swapped monitor encoding. Randomized streams are compared every cycle against a bench model.

// File: rtl/plm_pkg.sv
package plm_pkg;

    localparam int NUM_CH = 2;

    typedef enum logic [1:0] {
        PFD_IDLE = 2'd0,
        PFD_LEAD = 2'd1,   // reference edge came first
        PFD_LAG  = 2'd2    // feedback edge came first
    } pfd_state_e;

    typedef struct packed {
        logic drive;
        logic oe;
    } cp_cmd_t;

    // Map detector state and polarity onto the pump command.
    function automatic cp_cmd_t cp_encode(pfd_state_e st, logic pol, logic sleep);
        cp_cmd_t c;
        c.oe    = (st != PFD_IDLE) && !sleep;
        c.drive = c.oe && ((st == PFD_LEAD) == pol);
        return c;
    endfunction

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/plm_pfd.sv
module plm_pfd
    import plm_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    sleep,
    input  logic    pol,
    input  logic    fr,
    input  logic    fp,
    output cp_cmd_t cmd,
    output logic    zero_cmp
);

    logic       fr_q, fp_q;
    logic       fr_e, fp_e;
    pfd_state_e st, st_n;

    assign fr_e = fr & ~fr_q;
    assign fp_e = fp & ~fp_q;

    always_comb begin
        st_n = st;
        unique case (st)
            PFD_IDLE: begin
                if (fr_e && !fp_e)      st_n = PFD_LEAD;
                else if (fp_e && !fr_e) st_n = PFD_LAG;
            end
            PFD_LEAD: if (fp_e) st_n = PFD_IDLE;
            PFD_LAG:  if (fr_e) st_n = PFD_IDLE;
            default:  st_n = PFD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_q <= 1'b0;
            fp_q <= 1'b0;
        end else begin
            fr_q <= fr;
            fp_q <= fp;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || sleep) st <= PFD_IDLE;
        else              st <= st_n;
    end

    assign cmd      = cp_encode(st, pol, sleep);
    assign zero_cmp = (st == PFD_IDLE) && fr_e && fp_e && !sleep;

endmodule

// File: rtl/plm_lockdet.sv
module plm_lockdet
    import plm_pkg::*;
#(
    parameter int unsigned UNLOCK_W = 2,
    parameter int unsigned RELOCK_W = 4,
    parameter int unsigned QUAL_CNT = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic sleep,
    input  logic err_on,
    input  logic zero_cmp,
    output logic locked
);

    localparam int unsigned W_MAX = max2(UNLOCK_W, RELOCK_W) + 1;
    localparam int unsigned WW    = $clog2(W_MAX + 1);
    localparam int unsigned GW    = $clog2(QUAL_CNT + 1);
    localparam logic [WW-1:0] W_TOP = WW'(W_MAX);
    localparam logic [WW-1:0] W_UNL = WW'(UNLOCK_W);
    localparam logic [WW-1:0] W_REL = WW'(RELOCK_W);
    localparam logic [GW-1:0] G_TOP = GW'(QUAL_CNT);

    logic [WW-1:0] width_q, width_inc;
    logic [GW-1:0] good_q, good_inc;
    logic          pulse_done, good_evt, bad_evt;

    assign width_inc  = (width_q == W_TOP) ? W_TOP : width_q + 1'b1;
    assign good_inc   = (good_q == G_TOP) ? G_TOP : good_q + 1'b1;
    assign pulse_done = !err_on && (width_q != '0);
    assign good_evt   = pulse_done ? (width_q < W_UNL && width_q <= W_REL) : zero_cmp;
    assign bad_evt    = pulse_done && width_q < W_UNL && width_q > W_REL;

    always_ff @(posedge clk) begin
        if (rst || sleep) begin
            width_q <= '0;
            good_q  <= '0;
            locked  <= 1'b0;
        end else if (err_on) begin
            width_q <= width_inc;
            if (width_inc >= W_UNL) begin
                locked <= 1'b0;
                good_q <= '0;
            end
        end else begin
            width_q <= '0;
            if (good_evt) begin
                good_q <= good_inc;
                if (good_inc >= G_TOP) locked <= 1'b1;
            end else if (bad_evt) begin
                good_q <= '0;
            end
        end
    end

endmodule

// File: rtl/plm_pinmux.sv
module plm_pinmux
    import plm_pkg::*;
(
    input  logic [NUM_CH-1:0] ch_locked,
    input  logic [NUM_CH-1:0] sleep,
    input  logic [NUM_CH-1:0] fr,
    input  logic [NUM_CH-1:0] fp,
    input  logic              lds,
    input  logic              mon_ch,
    input  logic              mon_fb,
    output logic              ld_mon
);

    logic lock_all;
    logic mon_bit;

    assign lock_all = &(ch_locked | sleep);
    assign mon_bit  = mon_fb ? fp[mon_ch] : fr[mon_ch];
    assign ld_mon   = lds ? mon_bit : lock_all;

endmodule

// File: rtl/plm_top.sv
module plm_top
    import plm_pkg::*;
#(
    parameter int unsigned UNLOCK_W = 2,
    parameter int unsigned RELOCK_W = 4,
    parameter int unsigned QUAL_CNT = 3
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sleep,
    input  logic [1:0] fr,
    input  logic [1:0] fp,
    input  logic [1:0] pol,
    input  logic       lds,
    input  logic       mon_ch,
    input  logic       mon_fb,
    output logic [1:0] cp_drive,
    output logic [1:0] cp_oe,
    output logic       ld_mon
);

    logic [NUM_CH-1:0] ch_locked;

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        cp_cmd_t cmd;
        logic    zero_cmp;

        plm_pfd u_pfd (
            .clk      (clk),
            .rst      (rst),
            .sleep    (sleep[i]),
            .pol      (pol[i]),
            .fr       (fr[i]),
            .fp       (fp[i]),
            .cmd      (cmd),
            .zero_cmp (zero_cmp)
        );

        plm_lockdet #(
            .UNLOCK_W (UNLOCK_W),
            .RELOCK_W (RELOCK_W),
            .QUAL_CNT (QUAL_CNT)
        ) u_lock (
            .clk      (clk),
            .rst      (rst),
            .sleep    (sleep[i]),
            .err_on   (cmd.oe),
            .zero_cmp (zero_cmp),
            .locked   (ch_locked[i])
        );

        assign cp_oe[i]    = cmd.oe;
        assign cp_drive[i] = cmd.drive;
    end

    plm_pinmux u_mux (
        .ch_locked (ch_locked),
        .sleep     (sleep),
        .fr        (fr),
        .fp        (fp),
        .lds       (lds),
        .mon_ch    (mon_ch),
        .mon_fb    (mon_fb),
        .ld_mon    (ld_mon)
    );

endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
    parameter int unsigned UNLOCK_W = 2
) (
    input logic       clk,
    input logic       rst,
    input logic [1:0] sleep,
    input logic [1:0] fr,
    input logic [1:0] fp,
    input logic [1:0] pol,
    input logic       lds,
    input logic [1:0] cp_oe,
    input logic [1:0] cp_drive,
    input logic       ld_mon,
    input logic [1:0] lock_raw
);

    logic [1:0] fr_seen, fp_seen;
    logic [1:0] fr_rise, fp_rise;
    logic [7:0] run [2];

    assign fr_rise = fr & ~fr_seen;
    assign fp_rise = fp & ~fp_seen;

    always_ff @(posedge clk) begin
        if (rst) begin
            fr_seen <= '0;
            fp_seen <= '0;
        end else begin
            fr_seen <= fr;
            fp_seen <= fp;
        end
    end

    for (genvar i = 0; i < 2; i++) begin : g_chk
        always_ff @(posedge clk) begin
            if (rst || !cp_oe[i]) run[i] <= '0;
            else if (run[i] != 8'hFF) run[i] <= run[i] + 8'd1;
        end

        // R4: a pulse reaching the unlock width clears the channel flag
        a_r4_unlock_width: assert property (@(posedge clk) disable iff (rst)
            (cp_oe[i] && (32'(run[i]) + 1 >= UNLOCK_W)) |=> !lock_raw[i]);

        // R5: lock never returns in the middle of an error pulse
        a_r5_relock_idle: assert property (@(posedge clk) disable iff (rst)
            $rose(lock_raw[i]) |-> !$past(cp_oe[i]));

        // R3: power save floats the pump
        a_r3_sleep_float: assert property (@(posedge clk) disable iff (rst)
            sleep[i] |-> (!cp_oe[i] && !cp_drive[i]));

        // R1: a pulse opened by a lone reference edge drives the polarity level
        a_r1_lead_level: assert property (@(posedge clk) disable iff (rst)
            (cp_oe[i] && !$past(cp_oe[i]) && $past(fr_rise[i] && !fp_rise[i]))
            |-> (cp_drive[i] == pol[i]));
    end

    // R6: combined lock indication
    a_r6_lock_and: assert property (@(posedge clk) disable iff (rst)
        !lds |-> (ld_mon == &(lock_raw | sleep)));

endmodule

bind plm_top plm_checker #(.UNLOCK_W(UNLOCK_W)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .sleep    (sleep),
    .fr       (fr),
    .fp       (fp),
    .pol      (pol),
    .lds      (lds),
    .cp_oe    (cp_oe),
    .cp_drive (cp_drive),
    .ld_mon   (ld_mon),
    .lock_raw (ch_locked)
);

// File: tb/plm_top_tb.sv
`timescale 1ns/1ps
module plm_top_tb;

    localparam int UNL  = 2;
    localparam int REL  = 4;
    localparam int QUAL = 3;

    logic       clk = 0;
    logic       rst = 1;
    logic [1:0] sleep = 0, fr = 0, fp = 0, pol = 2'b11;
    logic       lds = 0, mon_ch = 0, mon_fb = 0;
    logic [1:0] cp_drive, cp_oe;
    logic       ld_mon;

    int tests = 0, fails = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    plm_top u_dut (
        .clk(clk), .rst(rst), .sleep(sleep), .fr(fr), .fp(fp), .pol(pol),
        .lds(lds), .mon_ch(mon_ch), .mon_fb(mon_fb),
        .cp_drive(cp_drive), .cp_oe(cp_oe), .ld_mon(ld_mon)
    );

    // Bench model: 0 idle, 1 reference leads, 2 feedback leads
    int m_st [2];
    int m_w  [2];
    int m_g  [2];
    bit m_lk [2];
    bit m_frq[2];
    bit m_fpq[2];

    always @(posedge clk) begin
        for (int i = 0; i < 2; i++) begin
            bit re, pe;
            re = fr[i] && !m_frq[i];
            pe = fp[i] && !m_fpq[i];
            if (rst) begin
                m_frq[i] = 0; m_fpq[i] = 0;
                m_st[i] = 0; m_w[i] = 0; m_g[i] = 0; m_lk[i] = 0;
            end else begin
                m_frq[i] = fr[i]; m_fpq[i] = fp[i];
                if (sleep[i]) begin
                    m_st[i] = 0; m_w[i] = 0; m_g[i] = 0; m_lk[i] = 0;
                end else begin
                    if (m_st[i] != 0) begin
                        if (m_w[i] < REL + 1) m_w[i]++;
                        if (m_w[i] >= UNL) begin m_lk[i] = 0; m_g[i] = 0; end
                    end else begin
                        bit good;
                        good = 0;
                        if (m_w[i] != 0) begin
                            if (m_w[i] < UNL && m_w[i] <= REL) good = 1;
                            else if (m_w[i] < UNL) m_g[i] = 0;
                        end else if (re && pe) good = 1;
                        m_w[i] = 0;
                        if (good) begin
                            if (m_g[i] < QUAL) m_g[i]++;
                            if (m_g[i] >= QUAL) m_lk[i] = 1;
                        end
                    end
                    case (m_st[i])
                        0: if (re && !pe) m_st[i] = 1; else if (pe && !re) m_st[i] = 2;
                        1: if (pe) m_st[i] = 0;
                        default: if (re) m_st[i] = 0;
                    endcase
                end
            end
        end
    end

    function automatic bit exp_oe(int i);
        return (m_st[i] != 0) && !sleep[i];
    endfunction

    function automatic bit exp_drive(int i);
        return exp_oe(i) && ((m_st[i] == 1) == pol[i]);
    endfunction

    function automatic bit exp_ld();
        if (lds) return mon_fb ? fp[mon_ch] : fr[mon_ch];
        return (m_lk[0] || sleep[0]) && (m_lk[1] || sleep[1]);
    endfunction

    task automatic check(string req, string what, int act, int expv);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, act, expv, $time);
        end
    endtask

    string cp_tag = "R1";
    string ld_tag = "R6";

    // Compare all outputs against the model, away from the clock edge.
    task automatic cmp_all();
        for (int i = 0; i < 2; i++) begin
            check(cp_tag, $sformatf("cp_oe[%0d]", i), cp_oe[i], exp_oe(i));
            check(cp_tag, $sformatf("cp_drive[%0d]", i), cp_drive[i], exp_drive(i));
        end
        check(ld_tag, "ld_mon", ld_mon, exp_ld());
    endtask

    // One cycle: apply inputs, compare at the negedge, return just after the next posedge.
    task automatic cyc(logic [1:0] f_r, logic [1:0] f_p);
        fr = f_r; fp = f_p;
        @(negedge clk);
        cmp_all();
        @(posedge clk);
        #1;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) cyc(2'b00, 2'b00);
    endtask

    task automatic coincide(logic [1:0] ch);
        cyc(ch, ch);
        cyc(2'b00, 2'b00);
    endtask

    // Pulse of width d on channel mask ch, reference leading.
    task automatic lead_pulse(logic [1:0] ch, int d);
        cyc(ch, 2'b00);
        for (int k = 1; k < d; k++) cyc(2'b00, 2'b00);
        cyc(2'b00, ch);
        cyc(2'b00, 2'b00);
    endtask

    initial begin
        #(4 * 60000);
        if (!finished) begin
            fails++; tests++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst = 0;
        @(negedge clk);
        // R8: reset state
        check("R8", "cp_oe", cp_oe, 0);
        check("R8", "ld_mon", ld_mon, 0);
        @(posedge clk); #1;

        // R2 / R5: coincident edges give no pump, and three of them relock
        cp_tag = "R2"; ld_tag = "R5";
        coincide(2'b11);
        coincide(2'b11);
        check("R5", "ld after two good", ld_mon, 0);
        cyc(2'b11, 2'b11);
        check("R2", "cp_oe coincident", cp_oe, 0);
        check("R5", "ld after third good", ld_mon, 1);
        idle(1);

        // R1: reference lead with pol=1, then pol=0, then feedback lead
        cp_tag = "R1"; ld_tag = "R9";
        cyc(2'b01, 2'b00);
        check("R1", "oe on lead", cp_oe[0], 1);
        check("R1", "drive lead pol1", cp_drive[0], 1);
        cyc(2'b00, 2'b01);
        check("R1", "oe closed", cp_oe[0], 0);
        idle(1);
        check("R9", "ld after 1-cycle pulse", ld_mon, 1);
        pol = 2'b10;
        cyc(2'b01, 2'b00);
        check("R1", "drive lead pol0", cp_drive[0], 0);
        cyc(2'b00, 2'b01);
        idle(1);
        pol = 2'b11;
        cyc(2'b00, 2'b01);
        check("R1", "drive lag pol1", cp_drive[0], 0);
        check("R1", "oe lag", cp_oe[0], 1);
        cyc(2'b01, 2'b00);
        idle(1);

        // R4: two-cycle pulse on channel 1 drops lock
        cp_tag = "R4"; ld_tag = "R4";
        lead_pulse(2'b10, 2);
        check("R4", "ld after 2-cycle pulse", ld_mon, 0);

        // R5: unlock in the middle of a good run restarts the count
        ld_tag = "R5";
        coincide(2'b10);
        coincide(2'b10);
        lead_pulse(2'b10, 3);
        coincide(2'b10);
        coincide(2'b10);
        check("R5", "ld not yet relocked", ld_mon, 0);
        lead_pulse(2'b10, 1);
        check("R5", "ld relocked via 1-cycle pulse", ld_mon, 1);

        // R3: sleep floats the pump, counts as locked, wakes unlocked
        cp_tag = "R3"; ld_tag = "R3";
        lead_pulse(2'b10, 3);
        check("R3", "ch1 unlocked before sleep", ld_mon, 0);
        sleep = 2'b10;
        cyc(2'b10, 2'b00);
        check("R3", "oe while sleeping", cp_oe[1], 0);
        check("R3", "ld with ch1 asleep", ld_mon, 1);
        cyc(2'b00, 2'b00);
        sleep = 2'b00;
        cyc(2'b00, 2'b00);
        check("R3", "ld after wake", ld_mon, 0);

        // R7: monitor selection
        ld_tag = "R7";
        lds = 1;
        for (int s = 0; s < 4; s++) begin
            mon_ch = s[1]; mon_fb = s[0];
            for (int v = 0; v < 16; v++) begin
                bit e;
                fr = v[1:0]; fp = v[3:2];
                #0.5;
                e = mon_fb ? fp[mon_ch] : fr[mon_ch];
                check("R7", $sformatf("monitor sel=%0d v=%0d", s, v), ld_mon, e);
            end
        end
        fr = 0; fp = 0;
        lds = 0;
        @(posedge clk); #1;

        // Random streams against the model
        cp_tag = "R1"; ld_tag = "R6";
        void'($urandom(32'h5eed_1234));
        for (int n = 0; n < 3000; n++) begin
            logic [1:0] rf, rp;
            rf = {($urandom % 4 == 0), ($urandom % 4 == 0)};
            rp = {($urandom % 4 == 0), ($urandom % 4 == 0)};
            if ($urandom % 50 == 0) sleep = 2'($urandom);
            if ($urandom % 40 == 0) pol = 2'($urandom);
            if ($urandom % 30 == 0) begin
                lds = ($urandom % 4 == 0);
                mon_ch = 1'($urandom); mon_fb = 1'($urandom);
            end
            cyc(rf, rp);
        end

        finished = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule